// File: doc/BRIEF.md
# Trimmable Nanosecond Time Counter

This block keeps a free-running nanosecond time value for packet timestamping. On every enabled reference clock it adds a programmable step to the count. The correction interval can be programmed. On every cycle that completes that interval, a second programmable step replaces the normal one. Software uses this to trim the effective frequency in small steps without changing the reference clock. The count can wrap at a programmable period value instead of at its natural power-of-two limit.

Software reaches the block through a simple word-wide register port. A write to the control word can also restart the count or take a snapshot of it. A write to the time word loads a new count directly. A read of the time word returns the most recent snapshot. The live count and a one-cycle wrap indication go to the compare channels next to the block.

Top module: `tsc_timebase`

## Requirements
- R1: Reset clears the count, the snapshot and every register. While reset is high and in the cycle after it, `time_now` reads 0 and `wrap_evt` is low.
- R2: When control bit 0 is 1, each clock adds the normal step to the count. The normal step is bits 6:0 of the step word at address 4. When control bit 0 is 0, the count holds.
- R3: A correction interval value P is written at address 3. When P is nonzero, the count adds the correction step (bits 14:8 of the step word) instead of the normal step on every (P+1)-th enabled cycle. The interval restarts after each correction. When P is 0, the correction step is never used.
- R4: When control bits 5 and 4 are both 1 and the sum of count and step reaches or exceeds the period value at address 2, the new count is that sum minus the period. In every other case the count wraps at 2^32.
- R5: `wrap_evt` is high for exactly the cycle in which a wrapped count first appears on `time_now`. It goes high only when control bit 7 is 1.
- R6: Writing the control word with bit 11 set copies the count held before that edge into the snapshot. Address 1 reads back the snapshot. No other write changes the snapshot. Bit 11 always reads back as 0.
- R7: Writing address 1 loads the written value into the count at that edge. Counting then continues from that value.
- R8: Writing the control word with bit 9 set clears the count and the correction interval at that edge. Bit 9 always reads back as 0.
- R9: Address 2 reads back the period value and address 3 reads back the correction interval in full. Address 4 reads back only bits 14:8 and 6:0. Address 0 reads back control bits 0, 4, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Register word address (0 control, 1 time, 2 period, 3 correction interval, 4 steps) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| time_now | output | 32 | Live count to the compare channels |
| wrap_evt | output | 1 | One-cycle wrap indication, gated by control bit 7 |

## Verification
The assertions watch several properties on every cycle. The count must hold while counting is off and no write arrives. A load or a restart must show on the next cycle. The snapshot must not move without a capture request. Under period reset with a period wide enough for the step, the count must stay below the period, and any wrap indication must follow a counting cycle. The exact place of each correction inside the interval, the value left after a wrap, the wrap at the natural limit and the register readback masking can only be shown by the bench. It checks the count after runs of known length with several step and interval patterns, and it checks the captured and read-back values.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL   = 3'd0,
        A_TIME   = 3'd1,
        A_PERIOD = 3'd2,
        A_CORR   = 3'd3,
        A_STEP   = 3'd4
    } reg_addr_e;

    // control word bit positions
    localparam int B_RUN     = 0;
    localparam int B_PRST_LO = 4;
    localparam int B_PRST_HI = 5;
    localparam int B_WEVT    = 7;
    localparam int B_RESTART = 9;
    localparam int B_SNAP    = 11;

    // step word: normal step at bit 0, correction step at bit 8
    localparam int CSTEP_LO = 8;

    typedef struct packed {
        logic       wevt;
        logic [1:0] prst;
        logic       run;
    } ctrl_t;

    function automatic logic prst_active(ctrl_t c);
        return &c.prst;
    endfunction

endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
    import tsc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt_live,
    output ctrl_t             ctrl_q,
    output logic              restart,
    output logic              load,
    output logic [CNT_W-1:0]  period_q,
    output logic [CNT_W-1:0]  corr_q,
    output logic [CNT_W-1:0]  snap_q,
    output logic [STEP_W-1:0] step_q,
    output logic [STEP_W-1:0] cstep_q,
    output logic [CNT_W-1:0]  rdata
);

    logic wr_ctrl;
    logic snap_req;

    assign wr_ctrl  = we && (addr == A_CTRL);
    assign restart  = wr_ctrl && wdata[B_RESTART];
    assign snap_req = wr_ctrl && wdata[B_SNAP];
    assign load     = we && (addr == A_TIME);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '0;
            corr_q   <= '0;
            snap_q   <= '0;
            step_q   <= '0;
            cstep_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run  <= wdata[B_RUN];
                ctrl_q.prst <= wdata[B_PRST_HI:B_PRST_LO];
                ctrl_q.wevt <= wdata[B_WEVT];
            end
            if (snap_req)
                snap_q <= cnt_live;
            if (we && addr == A_PERIOD)
                period_q <= wdata;
            if (we && addr == A_CORR)
                corr_q <= wdata;
            if (we && addr == A_STEP) begin
                step_q  <= wdata[STEP_W-1:0];
                cstep_q <= wdata[CSTEP_LO +: STEP_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_RUN]               = ctrl_q.run;
                rdata[B_PRST_HI:B_PRST_LO] = ctrl_q.prst;
                rdata[B_WEVT]              = ctrl_q.wevt;
            end
            A_TIME:   rdata = snap_q;
            A_PERIOD: rdata = period_q;
            A_CORR:   rdata = corr_q;
            A_STEP: begin
                rdata[STEP_W-1:0]         = step_q;
                rdata[CSTEP_LO +: STEP_W] = cstep_q;
            end
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/tsc_stepsel.sv
module tsc_stepsel #(
    parameter int CNT_W  = 32,
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              clear,
    input  logic [CNT_W-1:0]  corr_per,
    input  logic [STEP_W-1:0] step,
    input  logic [STEP_W-1:0] cstep,
    output logic [STEP_W-1:0] step_sel
);

    logic [CNT_W-1:0] phase_q;
    logic             corr_on;
    logic             fire;

    assign corr_on  = (corr_per != '0);
    assign fire     = corr_on && (phase_q >= corr_per);
    assign step_sel = fire ? cstep : step;

    always_ff @(posedge clk) begin
        if (rst || clear)
            phase_q <= '0;
        else if (adv) begin
            if (fire || !corr_on)
                phase_q <= '0;
            else
                phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/tsc_accum.sv
module tsc_accum #(
    parameter int CNT_W  = 32,
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              restart,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [STEP_W-1:0] step,
    input  logic              prst_on,
    input  logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              wrap_q
);

    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum;
    logic             hit_period;
    logic [CNT_W-1:0] nxt;
    logic             nxt_wrap;

    assign sum        = {1'b0, cnt_q} + SUM_W'(step);
    assign hit_period = prst_on && (sum >= {1'b0, period});

    always_comb begin
        if (hit_period) begin
            nxt      = CNT_W'(sum - {1'b0, period});
            nxt_wrap = 1'b1;
        end else begin
            nxt      = sum[CNT_W-1:0];
            nxt_wrap = sum[CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_val;
            wrap_q <= 1'b0;
        end else if (restart) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else if (adv) begin
            cnt_q  <= nxt;
            wrap_q <= nxt_wrap;
        end else begin
            wrap_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tsc_timebase.sv
module tsc_timebase
    import tsc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [CNT_W-1:0]  time_now,
    output logic              wrap_evt
);

    ctrl_t             ctrl_q;
    logic              restart;
    logic              load;
    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  corr_q;
    logic [CNT_W-1:0]  snap_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] cstep_q;
    logic [STEP_W-1:0] step_sel;
    logic              prst_on;
    logic              wrap_q;

    assign prst_on = prst_active(ctrl_q);

    tsc_regs #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cnt_live (time_now),
        .ctrl_q   (ctrl_q),
        .restart  (restart),
        .load     (load),
        .period_q (period_q),
        .corr_q   (corr_q),
        .snap_q   (snap_q),
        .step_q   (step_q),
        .cstep_q  (cstep_q),
        .rdata    (reg_rdata)
    );

    tsc_stepsel #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_stepsel (
        .clk      (clk),
        .rst      (rst),
        .adv      (ctrl_q.run),
        .clear    (restart),
        .corr_per (corr_q),
        .step     (step_q),
        .cstep    (cstep_q),
        .step_sel (step_sel)
    );

    tsc_accum #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .adv      (ctrl_q.run),
        .restart  (restart),
        .load     (load),
        .load_val (reg_wdata),
        .step     (step_sel),
        .prst_on  (prst_on),
        .period   (period_q),
        .cnt_q    (time_now),
        .wrap_q   (wrap_q)
    );

    assign wrap_evt = wrap_q && ctrl_q.wevt;

endmodule

// File: rtl/tsc_timebase_chk.sv
module tsc_timebase_chk
    import tsc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int STEP_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [CNT_W-1:0]  reg_wdata,
    input logic [CNT_W-1:0]  time_now,
    input logic              wrap_evt,
    input logic              run_en,
    input logic              prst_on,
    input logic [CNT_W-1:0]  period_q,
    input logic [CNT_W-1:0]  snap_q
);

    localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(1) << STEP_W;

    logic wr_ctrl;
    assign wr_ctrl = reg_we && (reg_addr == A_CTRL);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (time_now == '0 && !wrap_evt));

    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !reg_we) |=> $stable(time_now));

    assert_below_period_R4: assert property (@(posedge clk) disable iff (rst)
        (prst_on && run_en && !reg_we && period_q >= MIN_PERIOD && time_now < period_q)
        |=> (time_now < $past(period_q)));

    assert_wrap_after_count_R5: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |-> $past(run_en));

    assert_snap_only_on_request_R6: assert property (@(posedge clk) disable iff (rst)
        !(wr_ctrl && reg_wdata[B_SNAP]) |=> $stable(snap_q));

    assert_load_value_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_TIME) |=> (time_now == $past(reg_wdata)));

    assert_restart_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && reg_wdata[B_RESTART]) |=> (time_now == '0));

endmodule

bind tsc_timebase tsc_timebase_chk #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .time_now  (time_now),
    .wrap_evt  (wrap_evt),
    .run_en    (ctrl_q.run),
    .prst_on   (prst_on),
    .period_q  (period_q),
    .snap_q    (snap_q)
);

// File: tb/tb_tsc_timebase.sv
`timescale 1ns/1ps
module tb_tsc_timebase;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [31:0] time_now;
    logic        wrap_evt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tsc_timebase dut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .time_now  (time_now),
        .wrap_evt  (wrap_evt)
    );

    localparam logic [2:0] AC = 3'd0, AT = 3'd1, AP = 3'd2, AK = 3'd3, AS = 3'd4;

    typedef struct packed {
        logic [6:0]  inc;
        logic [6:0]  ci;
        logic [15:0] cp;
        logic [15:0] n;
        logic [31:0] exp;
    } vec_t;

    // expected = n*inc + (n/(cp+1))*(ci-inc) when cp != 0, else n*inc
    localparam vec_t VECS [8] = '{
        '{7'd8,   7'd8,   16'd0, 16'd10, 32'd80},
        '{7'd5,   7'd9,   16'd3, 16'd12, 32'd72},
        '{7'd10,  7'd6,   16'd1, 16'd7,  32'd58},
        '{7'd1,   7'd2,   16'd0, 16'd20, 32'd20},
        '{7'd3,   7'd0,   16'd4, 16'd15, 32'd36},
        '{7'd127, 7'd127, 16'd2, 16'd9,  32'd1143},
        '{7'd0,   7'd5,   16'd9, 16'd25, 32'd10},
        '{7'd7,   7'd8,   16'd6, 16'd14, 32'd100}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] snap_keep;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 time", time_now, 32'd0);
        check("R1 wrap", {31'd0, wrap_evt}, 32'd0);
        rst = 1'b0;
        idle(1);
        check("R1 time after release", time_now, 32'd0);
        rd(AC, r); check("R1 ctrl", r, 32'd0);
        rd(AT, r); check("R1 snapshot", r, 32'd0);
        rd(AS, r); check("R1 step", r, 32'd0);

        // R9: readback
        wr(AP, 32'hDEAD_BEEF); rd(AP, r); check("R9 period", r, 32'hDEAD_BEEF);
        wr(AK, 32'h8000_0003); rd(AK, r); check("R9 corr", r, 32'h8000_0003);
        wr(AS, 32'hFFFF_FFFF); rd(AS, r); check("R9 step mask", r, 32'h0000_7F7F);
        wr(AC, 32'h0000_00B0); rd(AC, r); check("R9 ctrl", r, 32'h0000_00B0);

        // R2 R3 R6: vector walk
        for (int i = 0; i < 8; i++) begin
            wr(AC, 32'd0);
            wr(AS, {17'd0, VECS[i].ci, 1'b0, VECS[i].inc});
            wr(AK, {16'd0, VECS[i].cp});
            wr(AC, 32'h0000_0201);
            idle(int'(VECS[i].n));
            check("R3 R2 count", time_now, VECS[i].exp);
            wr(AC, 32'h0000_0801);
            rd(AT, r); check("R6 snapshot", r, VECS[i].exp);
            rd(AC, r); check("R6 capture bit reads 0", r, 32'h0000_0001);
        end
        snap_keep = VECS[7].exp;

        // R4 R5: period wrap
        wr(AC, 32'd0);
        wr(AS, 32'h0000_000A);
        wr(AK, 32'd0);
        wr(AP, 32'd35);
        wr(AC, 32'h0000_02B1);
        idle(3);
        check("R4 before wrap", time_now, 32'd30);
        check("R5 no wrap yet", {31'd0, wrap_evt}, 32'd0);
        idle(1);
        check("R4 residue after wrap", time_now, 32'd5);
        check("R5 wrap pulse", {31'd0, wrap_evt}, 32'd1);
        idle(1);
        check("R4 after wrap", time_now, 32'd15);
        check("R5 pulse one cycle", {31'd0, wrap_evt}, 32'd0);

        // R5: gated off by bit 7
        wr(AC, 32'h0000_0231);
        idle(4);
        check("R4 wrap without event", time_now, 32'd5);
        check("R5 gated", {31'd0, wrap_evt}, 32'd0);

        // R4: only one period bit set -> no period wrap
        wr(AC, 32'h0000_0211);
        idle(4);
        check("R4 one bit only", time_now, 32'd40);

        // R4 R5 R7: natural wrap after a load
        wr(AC, 32'h0000_0081);
        wr(AT, 32'hFFFF_FFFA);
        check("R7 load", time_now, 32'hFFFF_FFFA);
        check("R5 no wrap on load", {31'd0, wrap_evt}, 32'd0);
        idle(1);
        check("R4 natural wrap", time_now, 32'd4);
        check("R5 natural wrap pulse", {31'd0, wrap_evt}, 32'd1);

        // R7: load then continue
        wr(AT, 32'd1000);
        check("R7 load value", time_now, 32'd1000);
        idle(1);
        check("R7 continue", time_now, 32'd1010);

        // R2: hold while disabled
        wr(AC, 32'd0);
        check("R2 last step", time_now, 32'd1020);
        idle(5);
        check("R2 hold", time_now, 32'd1020);

        // R6: snapshot untouched by other writes
        rd(AT, r); check("R6 snapshot kept", r, snap_keep);

        // R8: restart clears count and correction phase
        wr(AS, 32'h0000_0B01);
        wr(AK, 32'd2);
        wr(AC, 32'h0000_0201);
        idle(1);
        check("R8 pre", time_now, 32'd1);
        wr(AC, 32'h0000_0201);
        check("R8 cleared", time_now, 32'd0);
        rd(AC, r); check("R8 restart bit reads 0", r, 32'h0000_0001);
        idle(1);
        check("R8 phase cleared", time_now, 32'd1);
        idle(2);
        check("R3 R8 correction after restart", time_now, 32'd13);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule